// File: doc/BRIEF.md
# Three-Channel Input Capture Timer

This block is a free-running up-counter shared by three capture channels. Each channel presents a one-cycle event pulse that has already been filtered and edge-qualified upstream. On that pulse the block copies the counter value into the channel's own hold register and raises a sticky flag. The counter can be compared against a programmable value, and it can be cleared or reloaded from that value on a compare match, on a wrap past its maximum, or on any channel event. Its count source is either a prescaled copy of the system clock or rising edges on one of the channel input levels.

Software programs the block through a write-only strobe interface with three addresses: control word (address 0), compare value (address 1) and status clear (address 2). The counter, the hold registers and the flags are brought out directly. A single interrupt line combines every flag with its own enable.

Top module: `capture_timer`

## Requirements
- R1: After reset the counter, the hold registers, the flags and the interrupt are zero. The counter advances only while control bit 0 (run) and control bit 1 (count) are both 1.
- R2: While run is 1, an event pulse on channel x stores into hold register x the counter value held before that clock edge, and it sets flag bit x (x = 0..2).
- R3: With control bit 2 (compare) and run set, a counter equal to the compare value sets flag bit 3. If control bit 3 (clear on match) is also set, the counter is zeroed on that same edge.
- R4: A count step taken from the all-ones value sets flag bit 4 and wraps the counter to zero. With control bit 4 (reload on wrap) set, the counter loads the compare value instead.
- R5: Control bits 10..12 enable, per channel, a reload of the compare value into the counter on that channel's event. Bits 13..15 enable, per channel, a zeroing of the counter on that channel's event.
- R6: Control bits 7..5 pick the prescale code. Codes 0..7 give one count every 1, 4, 16, 32, 64, 96, 112 or 128 clocks.
- R7: Control bits 9..8 pick the count source. A value of 0 selects the prescaler. A value of 1, 2 or 3 selects rising edges of channel input 0, 1 or 2, sampled in the clock domain, and edges on the other inputs are ignored.
- R8: Writing address 2 clears each flag whose data bit is 1. Flags written with 0 keep their value.
- R9: The interrupt is the OR of each flag ANDed with control bit 16+i, where i is the flag's bit position.
- R10: When a flag is set and cleared on the same edge, the flag ends up set.
- R11: When a reload and a clear are both requested on the same edge, the counter takes the compare value. The hold register receives the value from before the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_evt | input | 3 | One-cycle capture event per channel |
| cap_lvl | input | 3 | Channel input levels, used as a count source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 compare, 2 status clear |
| wr_data | input | max(CNT_W,21) | Write data |
| cnt_o | output | CNT_W | Counter value |
| hold_o | output | 3*CNT_W | Hold registers, channel x at bits x*CNT_W upward |
| flags_o | output | 5 | Channel flags 0..2, match flag 3, wrap flag 4 |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with an 8-bit counter, so a wrap past all-ones happens after 256 counts. That brings the wrap flag, the reload on wrap and repeated compare matches within a few hundred clocks. An 8-bit counter still needs the full 128-clock prescale interval to be measured. Directed sequences cover each priority collision. A random phase then mixes control rewrites, events, level toggles and status clears against the bench's own model of the counter.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int NCH   = 3;
  localparam int NFLAG = NCH + 2;
  localparam int PRE_W = 7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // Control word, bit 0 at the bottom.
  typedef struct packed {
    logic [NFLAG-1:0] irq_en;
    logic [NCH-1:0]   clr_en;
    logic [NCH-1:0]   rld_en;
    logic [1:0]       src_sel;
    logic [2:0]       presc;
    logic             ovf_rld;
    logic             cmp_clr;
    logic             cmp_en;
    logic             cnt_en;
    logic             run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Terminal value of the prescale counter (ratio minus one).
  function automatic logic [PRE_W-1:0] presc_last(input logic [2:0] code);
    case (code)
      3'd0:    presc_last = 7'd0;
      3'd1:    presc_last = 7'd3;
      3'd2:    presc_last = 7'd15;
      3'd3:    presc_last = 7'd31;
      3'd4:    presc_last = 7'd63;
      3'd5:    presc_last = 7'd95;
      3'd6:    presc_last = 7'd111;
      default: presc_last = 7'd127;
    endcase
  endfunction
endpackage

// File: rtl/cap_tick_gen.sv
module cap_tick_gen
  import cap_timer_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           active,
  input  logic [2:0]     code,
  input  logic [1:0]     src_sel,
  input  logic [NCH-1:0] lvl,
  output logic           tick
);
  logic [PRE_W-1:0] pc_q;
  logic [NCH-1:0]   lvl_q;
  logic             pre_stb;
  logic [NCH:0]     src_vec;

  // ">=" keeps the divider sane when the code shrinks mid-count.
  assign pre_stb = active & (pc_q >= presc_last(code));
  assign src_vec = {lvl & ~lvl_q, pre_stb};
  assign tick    = active & src_vec[src_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl;
      if (!active || pre_stb) pc_q <= '0;
      else                    pc_q <= pc_q + 1'b1;
    end
  end

  AST_TICK_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !active |-> !tick); // R1
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmp_en,
  input  logic             cmp_clr,
  input  logic             ovf_rld,
  input  logic             evt_rld,
  input  logic             evt_clr,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             reload_req;
  logic             clear_req;

  assign match_o    = cmp_en & (cnt_q == cmp_val);
  assign ovf_o      = tick & (&cnt_q);
  assign reload_req = evt_rld | (ovf_o & ovf_rld);
  assign clear_req  = evt_clr | (match_o & cmp_clr);
  assign cnt_o      = cnt_q;

  // Priority: reload, then clear, then count.
  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (reload_req) cnt_q <= cmp_val;
    else if (clear_req)  cnt_q <= '0;
    else if (tick)       cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !evt_rld && !evt_clr && !match_o) |=> $stable(cnt_q)); // R1
  AST_RELOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (evt_rld && evt_clr) |=> cnt_q == $past(cmp_val)); // R11
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !ovf_rld && !evt_rld) |=> cnt_q == '0); // R4
  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (evt_clr && !evt_rld && !(ovf_o && ovf_rld)) |=> cnt_q == '0); // R5
endmodule

// File: rtl/cap_flags.sv
module cap_flags
  import cap_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic [NFLAG-1:0] ien_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flg_q;

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else     flg_q <= (flg_q & ~clr_i) | set_i;
  end

  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & ien_i);

  for (genvar i = 0; i < NFLAG; i++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flg_q[i] && !clr_i[i]) |=> flg_q[i]); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flg_q[i]); // R10
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 24,
  localparam int DATA_W = (CNT_W > CTRL_W) ? CNT_W : CTRL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       cap_evt,
  input  logic [NCH-1:0]       cap_lvl,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [NCH*CNT_W-1:0] hold_o,
  output logic [NFLAG-1:0]     flags_o,
  output logic                 irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_q;
  logic [NCH-1:0]   evt_v;
  logic             tick;
  logic             match;
  logic             ovf;
  logic [CNT_W-1:0] cnt;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == ADDR_CMP)  cmp_q  <= wr_data[CNT_W-1:0];
    end
  end

  assign evt_v    = cap_evt & {NCH{ctrl_q.run}};
  assign flag_set = {ovf, match, evt_v};
  assign flag_clr = (wr_en && wr_addr == ADDR_STAT) ? wr_data[NFLAG-1:0] : '0;

  cap_tick_gen u_tick (
    .clk     (clk),
    .rst     (rst),
    .active  (ctrl_q.run & ctrl_q.cnt_en),
    .code    (ctrl_q.presc),
    .src_sel (ctrl_q.src_sel),
    .lvl     (cap_lvl),
    .tick    (tick)
  );

  cap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cmp_en  (ctrl_q.cmp_en & ctrl_q.run),
    .cmp_clr (ctrl_q.cmp_clr),
    .ovf_rld (ctrl_q.ovf_rld),
    .evt_rld (|(evt_v & ctrl_q.rld_en)),
    .evt_clr (|(evt_v & ctrl_q.clr_en)),
    .cmp_val (cmp_q),
    .cnt_o   (cnt),
    .match_o (match),
    .ovf_o   (ovf)
  );

  cap_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .ien_i   (ctrl_q.irq_en),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );

  assign cnt_o = cnt;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_hold
    logic [CNT_W-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (rst)            hold_q <= '0;
      else if (evt_v[ch]) hold_q <= cnt;
    end
    assign hold_o[ch*CNT_W +: CNT_W] = hold_q;

    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (rst)
      evt_v[ch] |=> hold_q == $past(cnt)); // R2
  end
endmodule

// File: tb/capture_timer_tb.sv
module capture_timer_tb;
  localparam int W    = 8;
  localparam int DW   = 21;
  localparam int MAXV = 255;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cap_evt = '0;
  logic [2:0]    cap_lvl = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [W-1:0]  cnt_o;
  logic [3*W-1:0] hold_o;
  logic [4:0]    flags_o;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  capture_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .cap_evt(cap_evt), .cap_lvl(cap_lvl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .hold_o(hold_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int ratio [8] = '{1, 4, 16, 32, 64, 96, 112, 128};
  int m_cnt, m_cmp, m_pc;
  int m_hold [3];
  bit [4:0] m_flags;
  bit [2:0] m_prev;
  bit [DW-1:0] m_ctrl;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_pc = 0; m_flags = '0; m_prev = '0; m_ctrl = '0;
      foreach (m_hold[i]) m_hold[i] = 0;
    end else begin
      bit run, act, pstb, tk, match, ovf, rl, cl;
      bit [2:0] ev;
      int src, div;
      run  = m_ctrl[0];
      act  = m_ctrl[0] && m_ctrl[1];
      div  = ratio[m_ctrl[7:5]];
      src  = int'(m_ctrl[9:8]);
      pstb = act && (m_pc >= div - 1);
      if (src == 0) tk = pstb;
      else          tk = act && cap_lvl[src-1] && !m_prev[src-1];
      m_prev = cap_lvl;
      if (!act || pstb) m_pc = 0; else m_pc = m_pc + 1;
      ev    = run ? cap_evt : 3'b000;
      match = m_ctrl[2] && run && (m_cnt == m_cmp);
      ovf   = tk && (m_cnt == MAXV);
      rl    = ((ev & m_ctrl[12:10]) != 0) || (ovf && m_ctrl[4]);
      cl    = ((ev & m_ctrl[15:13]) != 0) || (match && m_ctrl[3]);
      for (int c = 0; c < 3; c++) if (ev[c]) m_hold[c] = m_cnt;
      if (rl)      m_cnt = m_cmp;
      else if (cl) m_cnt = 0;
      else if (tk) m_cnt = (m_cnt + 1) % (MAXV + 1);
      if (wr_en && wr_addr == 2'd2) m_flags = m_flags & ~wr_data[4:0];
      m_flags = m_flags | {ovf, match, ev};
      if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data;
      if (wr_en && wr_addr == 2'd1) m_cmp = int'(wr_data[W-1:0]);
    end
  end

  // Compared on every falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 counter vs model", 32'(cnt_o), 32'(m_cnt));
      for (int c = 0; c < 3; c++)
        chk("R2 hold vs model", 32'(hold_o[c*W +: W]), 32'(m_hold[c]));
      chk("R8 flags vs model", 32'(flags_o), 32'(m_flags));
      chk("R9 irq vs model", 32'(irq_o), 32'(|(m_flags & m_ctrl[20:16])));
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [DW-1:0] mk(input bit run, input bit cen, input bit cmpen,
      input bit cmpclr, input bit ovfr, input int pre, input int src,
      input int rld, input int clr, input int ien);
    logic [DW-1:0] d = '0;
    d[0] = run; d[1] = cen; d[2] = cmpen; d[3] = cmpclr; d[4] = ovfr;
    d[7:5] = 3'(pre); d[9:8] = 2'(src); d[12:10] = 3'(rld);
    d[15:13] = 3'(clr); d[20:16] = 5'(ien);
    return d;
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] m);
    cap_evt = m;
    @(negedge clk);
    cap_evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [4:0] f;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset cnt", 32'(cnt_o), 0);
    chk("R1 reset hold", 32'(hold_o), 0);
    chk("R1 reset flags", 32'(flags_o), 0);
    chk("R1 reset irq", 32'(irq_o), 0);

    // R1 run without count: counter frozen
    wr(0, mk(1,0,0,0,0,0,0,0,0,0));
    idle(10);
    chk("R1 no count without enable", 32'(cnt_o), 0);

    // R2 capture while counting each clock
    wr(0, mk(1,1,0,0,0,0,0,0,0,0));
    idle(17);
    v = cnt_o;
    pulse(3'b010);
    chk("R2 hold1 gets prior count", 32'(hold_o[W +: W]), 32'(v));
    chk("R2 flag1 set", 32'(flags_o[1]), 1);

    // R6 prescaler ratios
    for (int code = 0; code < 8; code++) begin
      wr(0, mk(1,1,0,0,0,code,0,0,0,0));
      v = cnt_o;
      while (cnt_o == v) @(negedge clk);
      v = cnt_o; n = 0;
      while (cnt_o == v) begin @(negedge clk); n++; end
      chk("R6 prescale interval", 32'(n), 32'(ratio[code]));
    end

    // R7 channel 1 rising edges as count source, channel 0 edges ignored
    wr(0, mk(1,1,0,0,0,0,2,0,0,0));
    idle(2);
    v = cnt_o;
    for (int k = 0; k < 5; k++) begin
      cap_lvl = 3'b011; idle(2);
      cap_lvl = 3'b000; idle(2);
    end
    cap_lvl = 3'b001; idle(2); cap_lvl = 3'b000; idle(2);
    chk("R7 five edges counted", 32'(cnt_o), 32'(W'(v + 5)));

    // R3 compare with clear on match
    wr(2, 21'h1F);
    wr(1, 21'd10);
    wr(0, mk(1,0,0,0,0,0,0,0,1,0));
    pulse(3'b001);
    chk("R5 clear on event", 32'(cnt_o), 0);
    wr(0, mk(1,1,1,1,0,0,0,0,0,0));
    idle(40);
    chk("R3 match flag", 32'(flags_o[3]), 1);
    chk("R3 counter bounded by compare", 32'(cnt_o <= 10), 1);

    // R4 wrap without reload
    wr(0, mk(1,1,0,0,0,0,0,0,0,0));
    idle(300);
    chk("R4 wrap flag", 32'(flags_o[4]), 1);
    wr(0, mk(1,0,0,0,0,0,0,0,0,0));
    f = flags_o;
    wr(2, 21'h0);
    chk("R8 write zero keeps flags", 32'(flags_o), 32'(f));
    wr(2, 21'h10);
    chk("R8 wrap flag cleared", 32'(flags_o[4]), 0);
    chk("R8 other flags kept", 32'(flags_o[3:0]), 32'(f[3:0]));

    // R4 wrap with reload from compare
    wr(1, 21'd200);
    wr(0, mk(1,1,0,0,1,0,0,0,0,0));
    idle(300);
    chk("R4 reload keeps count high", 32'(cnt_o >= 200), 1);
    chk("R4 wrap flag again", 32'(flags_o[4]), 1);

    // R5 per-channel reload only / clear only
    wr(1, 21'd77);
    wr(0, mk(1,1,0,0,0,0,0,3'b100,3'b010,0));
    pulse(3'b100);
    chk("R5 reload on ch2", 32'(cnt_o), 77);
    idle(3);
    pulse(3'b010);
    chk("R5 clear on ch1", 32'(cnt_o), 0);

    // R11 reload and clear together
    wr(0, mk(1,1,0,0,0,0,0,3'b001,3'b001,0));
    idle(5);
    v = cnt_o;
    pulse(3'b001);
    chk("R11 reload beats clear", 32'(cnt_o), 77);
    chk("R11 hold0 has prior value", 32'(hold_o[0 +: W]), 32'(v));

    // R9 interrupt masking
    wr(0, mk(1,0,0,0,0,0,0,0,0,5'b00100));
    wr(2, 21'h1F);
    pulse(3'b001);
    chk("R9 masked flag gives no irq", 32'(irq_o), 0);
    pulse(3'b100);
    chk("R9 enabled flag raises irq", 32'(irq_o), 1);
    wr(2, 21'h04);
    chk("R9 irq drops after clear", 32'(irq_o), 0);

    // R10 set and clear on the same edge
    cap_evt = 3'b100; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 21'h04;
    @(negedge clk);
    cap_evt = '0; wr_en = 1'b0;
    chk("R10 set wins", 32'(flags_o[2]), 1);
    wr(2, 21'h04);
    chk("R10 later clear works", 32'(flags_o[2]), 0);

    // Random mix, checked by the model every clock
    for (int i = 0; i < 4000; i++) begin
      cap_evt = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
      if (($urandom % 3) == 0) cap_lvl = 3'($urandom);
      case ($urandom % 40)
        0: begin wr_en = 1; wr_addr = 2'd0;
             wr_data = mk(1'($urandom % 5 != 0), 1'($urandom % 4 != 0), 1'($urandom),
                          1'($urandom), 1'($urandom), int'($urandom % 3),
                          int'($urandom % 4), int'($urandom % 8), int'($urandom % 8),
                          int'($urandom % 32)); end
        1: begin wr_en = 1; wr_addr = 2'd1; wr_data = DW'($urandom % 256); end
        2: begin wr_en = 1; wr_addr = 2'd2; wr_data = DW'($urandom % 32); end
        default: wr_en = 0;
      endcase
      @(negedge clk);
    end
    wr_en = 0; cap_evt = '0;
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule